// File: doc/BRIEF.md
# Protected Watchdog Reset Timer

This block is an up-counting watchdog. An 8-bit count advances once per tick. Software chooses where the tick comes from: a free-running divider of the system clock, or a divider driven by single-cycle pulses from a slower sub-clock. A small register port gives software two registers. The control register holds the protection, run, guard and source bits. The count register can be preloaded at any time, which sets how many ticks remain before expiry.

The counter only starts after a protected sequence. One write unlocks the control register. A second write sets the run bit and, in the same write, clears the guard bit. When a tick arrives while the count is at its all-ones value, the count wraps. One clock later the block raises an internal reset of fixed length. While that reset is high, the watchdog puts its own state back to idle and takes no register writes. The reset is meant for the chip's reset sequencer. All logic runs on one clock, and each tick source is a clock enable.

Top module: `prot_wdt`

## Requirements
- R1: After system reset, `count_rd_o` is 0x00, `ctrl_rd_o` is 0x00 and `wdt_rst_o` is 0.
- R2: The control register uses these bits: bit 0 is unlock, bit 1 is run, bit 2 is guard and bit 3 is source. A control write (`reg_addr_i`=0) changes the run bit only when two things hold: the stored unlock bit was already 1, and the same write carries guard=0. Any other control write leaves run unchanged. Each control write loads unlock and source directly from the written data.
- R3: Enabling takes two writes. The first write of 0x01 sets unlock. The second write of 0x03 sets run. After that, `ctrl_rd_o` reads 0x03 and the count advances.
- R4: While run is 1, the count rises by exactly one per selected tick. With source=0, a tick comes every 2^SYS_DIV_LOG2 clock cycles; the default gives 8192. With source=1, a tick comes every 2^SUB_DIV_LOG2 pulses of `sub_tick_i`; the default gives 32. Both dividers start from zero at system reset.
- R5: A count write (`reg_addr_i`=1) loads the value at the next clock edge, whether run is set or not. If a tick falls in the same cycle, the write takes priority. Counting then continues upward from the loaded value, so expiry comes after 256 minus the preload ticks.
- R6: While run is 0, the count holds its value unless software writes it.
- R7: A tick at count 0xFF wraps the count to 0x00. `wdt_rst_o` rises exactly one clock cycle after the edge where the wrap happens.
- R8: `wdt_rst_o` stays high for exactly RST_CYCLES clock cycles; the default is 512.
- R9: From the cycle `wdt_rst_o` rises until it falls, the count reads 0x00 and the unlock and run bits read 0. Register writes made during the pulse are ignored. The source bit keeps its value.
- R10: The guard bit is write-only and always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state is on this clock |
| rst_n | input | 1 | Active-low synchronous system reset |
| sub_tick_i | input | 1 | Single-cycle pulse for each sub-clock period |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | Register select: 0 control, 1 count |
| reg_wdata_i | input | CNT_W | Write data |
| ctrl_rd_o | output | CNT_W | Control register readback |
| count_rd_o | output | CNT_W | Current count |
| wdt_rst_o | output | 1 | Internal watchdog reset pulse |

## Verification
The hardest state to reach from the ports is the wrap of the count from 0xFF to 0x00, followed by the one-cycle gap before reset and then the full pulse. Counting up from zero would take thousands of cycles. The bench instead shrinks the system-clock divider to 8 cycles and preloads 0xF8, so the wrap comes after eight ticks. It watches every cycle to find the exact wrap cycle, measures the pulse length, and tries register writes in the middle of the pulse. The sub-clock path is exercised separately: the bench starts from a fresh reset so the sub-clock divider phase is known, and then sends a counted number of pulses.

// File: rtl/pwdt_pkg.sv
package pwdt_pkg;

   // Control register bit positions
   localparam int CTL_UNLOCK = 0;
   localparam int CTL_RUN    = 1;
   localparam int CTL_GUARD  = 2;
   localparam int CTL_SRC    = 3;
   localparam int CTL_BITS   = 4;

   typedef enum logic {
      ADDR_CTL = 1'b0,
      ADDR_CNT = 1'b1
   } pwdt_addr_e;

   typedef struct packed {
      logic src;
      logic run;
      logic unlock;
   } pwdt_ctl_t;

endpackage

// File: rtl/pwdt_prescale.sv
module pwdt_prescale #(
   parameter int DIV_LOG2 = 13
) (
   input  logic clk,
   input  logic rst_n,
   input  logic step_i,
   output logic tick_o
);

   initial begin
      assert (DIV_LOG2 >= 0 && DIV_LOG2 <= 24)
         else $error("pwdt_prescale: DIV_LOG2 out of range");
   end

   generate
      if (DIV_LOG2 == 0) begin : g_pass
         assign tick_o = step_i;
      end else begin : g_div
         logic [DIV_LOG2-1:0] phase_q;

         always_ff @(posedge clk) begin
            if (!rst_n)
               phase_q <= '0;
            else if (step_i)
               phase_q <= phase_q + 1'b1;
         end

         assign tick_o = step_i && (&phase_q);
      end
   endgenerate

endmodule

// File: rtl/pwdt_ctl.sv
module pwdt_ctl
   import pwdt_pkg::*;
(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                kill_i,
   input  logic                wr_i,
   input  logic [CTL_BITS-1:0] wdata_i,
   output pwdt_ctl_t           ctl_o
);

   pwdt_ctl_t ctl_q;
   logic      may_toggle;

   assign may_toggle = ctl_q.unlock && !wdata_i[CTL_GUARD];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl_q <= '0;
      end else if (kill_i) begin
         ctl_q.run    <= 1'b0;
         ctl_q.unlock <= 1'b0;
      end else if (wr_i) begin
         ctl_q.unlock <= wdata_i[CTL_UNLOCK];
         ctl_q.src    <= wdata_i[CTL_SRC];
         if (may_toggle)
            ctl_q.run <= wdata_i[CTL_RUN];
      end
   end

   assign ctl_o = ctl_q;

endmodule

// File: rtl/pwdt_count.sv
module pwdt_count #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             kill_i,
   input  logic             run_i,
   input  logic             tick_i,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   output logic [CNT_W-1:0] count_o,
   output logic             ovf_o
);

   localparam logic [CNT_W-1:0] CNT_TOP = '1;

   logic [CNT_W-1:0] count_q;
   logic             ovf_q;

   always_ff @(posedge clk) begin
      if (!rst_n || kill_i) begin
         count_q <= '0;
         ovf_q   <= 1'b0;
      end else begin
         ovf_q <= 1'b0;
         if (load_i) begin
            count_q <= load_val_i;
         end else if (run_i && tick_i) begin
            count_q <= count_q + 1'b1;
            if (count_q == CNT_TOP)
               ovf_q <= 1'b1;
         end
      end
   end

   assign count_o = count_q;
   assign ovf_o   = ovf_q;

endmodule

// File: rtl/pwdt_pulse.sv
module pwdt_pulse #(
   parameter int RST_CYCLES = 512
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic active_o
);

   localparam int LEN_W = $clog2(RST_CYCLES + 1);
   localparam logic [LEN_W-1:0] LEN_LAST = LEN_W'(RST_CYCLES - 1);

   logic [LEN_W-1:0] left_q;
   logic             active_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         left_q   <= '0;
      end else if (active_q) begin
         if (left_q == '0)
            active_q <= 1'b0;
         else
            left_q <= left_q - 1'b1;
      end else if (start_i) begin
         active_q <= 1'b1;
         left_q   <= LEN_LAST;
      end
   end

   assign active_o = active_q;

endmodule

// File: rtl/prot_wdt.sv
module prot_wdt
   import pwdt_pkg::*;
#(
   parameter int CNT_W        = 8,
   parameter int SYS_DIV_LOG2 = 13,
   parameter int SUB_DIV_LOG2 = 5,
   parameter int RST_CYCLES   = 512
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sub_tick_i,
   input  logic             reg_wr_i,
   input  logic             reg_addr_i,
   input  logic [CNT_W-1:0] reg_wdata_i,
   output logic [CNT_W-1:0] ctrl_rd_o,
   output logic [CNT_W-1:0] count_rd_o,
   output logic             wdt_rst_o
);

   initial begin
      assert (CNT_W >= CTL_BITS)
         else $error("prot_wdt: CNT_W too narrow for control register");
      assert (RST_CYCLES >= 1)
         else $error("prot_wdt: RST_CYCLES must be at least 1");
   end

   logic      sys_tick;
   logic      sub_tick;
   logic      tick;
   logic      ovf;
   logic      pulse_on;
   logic      kill;
   logic      wr_ctl;
   logic      wr_cnt;
   pwdt_ctl_t ctl;

   assign kill   = ovf || pulse_on;
   assign wr_ctl = reg_wr_i && (pwdt_addr_e'(reg_addr_i) == ADDR_CTL);
   assign wr_cnt = reg_wr_i && (pwdt_addr_e'(reg_addr_i) == ADDR_CNT);

   pwdt_prescale #(.DIV_LOG2(SYS_DIV_LOG2)) u_sys_div (
      .clk    (clk),
      .rst_n  (rst_n),
      .step_i (1'b1),
      .tick_o (sys_tick)
   );

   pwdt_prescale #(.DIV_LOG2(SUB_DIV_LOG2)) u_sub_div (
      .clk    (clk),
      .rst_n  (rst_n),
      .step_i (sub_tick_i),
      .tick_o (sub_tick)
   );

   assign tick = ctl.src ? sub_tick : sys_tick;

   pwdt_ctl u_ctl (
      .clk     (clk),
      .rst_n   (rst_n),
      .kill_i  (kill),
      .wr_i    (wr_ctl),
      .wdata_i (reg_wdata_i[CTL_BITS-1:0]),
      .ctl_o   (ctl)
   );

   pwdt_count #(.CNT_W(CNT_W)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .kill_i     (kill),
      .run_i      (ctl.run),
      .tick_i     (tick),
      .load_i     (wr_cnt),
      .load_val_i (reg_wdata_i),
      .count_o    (count_rd_o),
      .ovf_o      (ovf)
   );

   pwdt_pulse #(.RST_CYCLES(RST_CYCLES)) u_pulse (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (ovf),
      .active_o (pulse_on)
   );

   always_comb begin
      ctrl_rd_o             = '0;
      ctrl_rd_o[CTL_UNLOCK] = ctl.unlock;
      ctrl_rd_o[CTL_RUN]    = ctl.run;
      ctrl_rd_o[CTL_SRC]    = ctl.src;
   end

   assign wdt_rst_o = pulse_on;

endmodule

// File: rtl/prot_wdt_chk.sv
module prot_wdt_chk #(
   parameter int CNT_W      = 8,
   parameter int RST_CYCLES = 512
) (
   input logic             clk,
   input logic             rst_n,
   input logic             reg_wr_i,
   input logic             reg_addr_i,
   input logic [CNT_W-1:0] reg_wdata_i,
   input logic [CNT_W-1:0] ctrl_rd_o,
   input logic [CNT_W-1:0] count_rd_o,
   input logic             wdt_rst_o
);

   int unsigned high_len_q;

   always_ff @(posedge clk) begin
      if (!rst_n || !wdt_rst_o)
         high_len_q <= 0;
      else
         high_len_q <= high_len_q + 1;
   end

   // R2
   run_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ctrl_rd_o[1]) |-> $past(reg_wr_i && !reg_addr_i && reg_wdata_i[1]
                                    && !reg_wdata_i[2] && ctrl_rd_o[0]));

   // R4
   step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_rd_o[1] && !reg_wr_i && !wdt_rst_o) |=>
         (count_rd_o == $past(count_rd_o) || count_rd_o == $past(count_rd_o) + 1'b1
          || count_rd_o == '0));

   // R6
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_rd_o[1] && !(reg_wr_i && reg_addr_i)) |=> $stable(count_rd_o));

   // R7
   rst_after_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wdt_rst_o) |-> ($past(count_rd_o, 2) == '1 && $past(count_rd_o) == '0));

   // R8
   pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wdt_rst_o) |-> high_len_q == RST_CYCLES);

   // R8
   pulse_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wdt_rst_o |-> high_len_q < RST_CYCLES);

   // R9
   pulse_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wdt_rst_o |-> (count_rd_o == '0 && ctrl_rd_o[1:0] == 2'b00));

   // R10
   guard_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr_i && !reg_addr_i && reg_wdata_i[2]) |=> !ctrl_rd_o[2]);

endmodule

bind prot_wdt prot_wdt_chk #(.CNT_W(CNT_W), .RST_CYCLES(RST_CYCLES)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .reg_wr_i    (reg_wr_i),
   .reg_addr_i  (reg_addr_i),
   .reg_wdata_i (reg_wdata_i),
   .ctrl_rd_o   (ctrl_rd_o),
   .count_rd_o  (count_rd_o),
   .wdt_rst_o   (wdt_rst_o)
);

// File: tb/prot_wdt_test.sv
`timescale 1ns/1ps
module prot_wdt_test;

   localparam int SYS_LOG2 = 3;
   localparam int SUB_LOG2 = 2;
   localparam int PULSE    = 512;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sub_tick = 1'b0;
   logic       wr = 1'b0;
   logic       addr = 1'b0;
   logic [7:0] wdata = 8'h00;
   logic [7:0] ctrl_rd;
   logic [7:0] count_rd;
   logic       wdt_rst;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   prot_wdt #(
      .CNT_W(8), .SYS_DIV_LOG2(SYS_LOG2), .SUB_DIV_LOG2(SUB_LOG2), .RST_CYCLES(PULSE)
   ) uut (
      .clk(clk), .rst_n(rst_n), .sub_tick_i(sub_tick), .reg_wr_i(wr),
      .reg_addr_i(addr), .reg_wdata_i(wdata), .ctrl_rd_o(ctrl_rd),
      .count_rd_o(count_rd), .wdt_rst_o(wdt_rst)
   );

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      wr = 1'b0;
      sub_tick = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic reg_write(input logic a, input logic [7:0] d);
      @(negedge clk);
      wr = 1'b1;
      addr = a;
      wdata = d;
      @(negedge clk);
      wr = 1'b0;
   endtask

   task automatic sub_pulses(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         sub_tick = 1'b1;
         @(negedge clk);
         sub_tick = 1'b0;
      end
      @(negedge clk);
   endtask

   task automatic t_reset();
      do_reset();
      @(negedge clk);
      check("R1 count", count_rd, 8'h00);
      check("R1 ctrl", ctrl_rd, 8'h00);
      check("R1 rst", wdt_rst, 0);
   endtask

   task automatic t_protect();
      do_reset();
      reg_write(1'b0, 8'h02);
      check("R2 run while locked", ctrl_rd, 8'h00);
      reg_write(1'b0, 8'h03);
      check("R2 unlock and run in one write", ctrl_rd, 8'h01);
      reg_write(1'b0, 8'h07);
      check("R2 guard written 1", ctrl_rd, 8'h01);
      check("R10 guard reads 0", ctrl_rd[2], 0);
      reg_write(1'b0, 8'h03);
      check("R3 second write enables", ctrl_rd, 8'h03);
      reg_write(1'b0, 8'h01);
      check("R2 run cleared when unlocked", ctrl_rd, 8'h01);
   endtask

   task automatic t_rate();
      int gap;
      logic [7:0] prev;
      do_reset();
      reg_write(1'b0, 8'h01);
      reg_write(1'b0, 8'h03);
      check("R3 enabled", ctrl_rd, 8'h03);
      reg_write(1'b1, 8'h40);
      check("R5 preload while running", count_rd, 8'h40);
      prev = count_rd;
      while (count_rd == prev) @(negedge clk);
      check("R4 step from preload", count_rd, 8'h41);
      prev = count_rd;
      gap = 0;
      while (count_rd == prev && gap < 100) begin
         @(negedge clk);
         gap++;
      end
      check("R4 tick period", gap, 1 << SYS_LOG2);
      check("R4 next value", count_rd, 8'h42);
   endtask

   task automatic t_hold();
      logic [7:0] held;
      reg_write(1'b0, 8'h01);
      held = count_rd;
      repeat (40) @(negedge clk);
      check("R6 count held while stopped", count_rd, held);
      reg_write(1'b1, 8'h77);
      check("R5 write while stopped", count_rd, 8'h77);
      repeat (40) @(negedge clk);
      check("R6 written value held", count_rd, 8'h77);
   endtask

   task automatic t_sub();
      do_reset();
      reg_write(1'b0, 8'h09);
      reg_write(1'b0, 8'h0B);
      check("R3 enabled on sub source", ctrl_rd, 8'h0B);
      reg_write(1'b1, 8'h10);
      repeat (40) @(negedge clk);
      check("R4 no system ticks on sub source", count_rd, 8'h10);
      sub_pulses(8);
      check("R4 eight sub pulses", count_rd, 8'h12);
      sub_pulses(3);
      check("R4 partial sub period", count_rd, 8'h12);
      sub_pulses(1);
      check("R4 sub period completes", count_rd, 8'h13);
   endtask

   task automatic t_overflow();
      logic [7:0] prev;
      int steps;
      int guard_cnt;
      int high;
      bit wrapped;
      do_reset();
      reg_write(1'b0, 8'h01);
      reg_write(1'b0, 8'h03);
      reg_write(1'b1, 8'hF8);
      check("R5 preload F8", count_rd, 8'hF8);
      steps = 0;
      wrapped = 1'b0;
      guard_cnt = 0;
      prev = count_rd;
      while (!wrapped && guard_cnt < 500) begin
         @(negedge clk);
         guard_cnt++;
         if (count_rd != prev) begin
            steps++;
            if (prev == 8'hFF && count_rd == 8'h00) wrapped = 1'b1;
            prev = count_rd;
         end
      end
      check("R7 wrap seen", wrapped, 1);
      check("R5 ticks to expiry from F8", steps, 8);
      check("R7 no reset in wrap cycle", wdt_rst, 0);
      @(negedge clk);
      check("R7 reset one cycle after wrap", wdt_rst, 1);
      check("R9 count cleared in pulse", count_rd, 8'h00);
      check("R9 ctrl cleared in pulse", ctrl_rd, 8'h00);
      high = 1;
      repeat (20) @(negedge clk);
      high += 20;
      @(negedge clk);
      wr = 1'b1; addr = 1'b0; wdata = 8'h01;
      @(negedge clk);
      wr = 1'b1; addr = 1'b1; wdata = 8'h55;
      @(negedge clk);
      wr = 1'b0;
      high += 3;
      check("R9 count write ignored in pulse", count_rd, 8'h00);
      check("R9 ctrl write ignored in pulse", ctrl_rd, 8'h00);
      guard_cnt = 0;
      while (wdt_rst && guard_cnt < 2000) begin
         @(negedge clk);
         guard_cnt++;
         if (wdt_rst) high++;
      end
      check("R8 pulse length", high, PULSE);
      repeat (30) @(negedge clk);
      check("R9 idle after pulse", count_rd, 8'h00);
      check("R9 ctrl idle after pulse", ctrl_rd, 8'h00);
   endtask

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_protect();
      t_rate();
      t_hold();
      t_sub();
      t_overflow();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule